// File: doc/BRIEF.md
# Masked Key Vault

The vault keeps one network encryption key on chip and never holds or emits it in the clear at its edge. The only copy it stores is the key masked with a per-device security value, called Z here. Z is fetched from a random-value port. Masking is a plain XOR of the key with Z repeated across the key width. A host reads back only that masked copy, so it can recover the key only if it already knows Z.

After reset the vault holds a built-in initial key that is meant to be replaced. A new key never arrives alone. The host sends the new key XORed with the key currently held, and the vault recovers the new key internally. A rekey command draws a fresh Z, unmasks the key with the old Z and masks it again with the new one, committing everything in a single step. While the vault waits for the random word it is busy and accepts no command.

Commands use a valid/ready handshake. A command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. The host must hold `cmd_valid`, `cmd_op` and `cmd_data` steady until that edge. `cmd_ready` is low while a read response is shown and during a rekey. The random port also uses valid/ready: a word transfers on an edge where `rnd_valid` and `rnd_ready` are both high, and `rnd_ready` is high only while a rekey waits. The response side has no back-pressure: `rsp_valid` is a one-cycle strobe.

Top module: `wrapped_key_vault`

## Requirements
- R1: After reset `cmd_ready` is 1, `busy`, `rnd_ready`, `rsp_valid` and `err` are 0, no Z is loaded, and the held key equals the `INIT_KEY` parameter.
- R2: An update command (op code 2'b01) whose payload M is accepted with a Z loaded replaces the held key K with M ^ K.
- R3: A read command (op code 2'b00) returns K ^ {Z,Z,Z,Z} on `rsp_data`, where Z is 32 bits wide and repeated to fill the 128-bit key width.
- R4: A read response shows `rsp_valid` high in exactly the one cycle after the accepting edge, and `cmd_ready` is low in that cycle.
- R5: A rekey command (op code 2'b10) waits for one random word Z2. After that word transfers, the held key is unchanged and later reads return K ^ {Z2,Z2,Z2,Z2}. The stored state stays unchanged while the word has not arrived.
- R6: From the accepting edge of a rekey until the edge on which the random word transfers, `busy` and `rnd_ready` are 1 and `cmd_ready` is 0. A command held valid in that time is accepted on the next edge after the transfer, and it then uses the new Z.
- R7: An update or read accepted before any Z has been loaded raises `err` for the one cycle after the accepting edge, gives no response, and leaves the key unchanged.
- R8: The reserved op code 2'b11 raises `err` for one cycle and changes nothing.
- R9: Outside a rekey `rnd_ready` is 0, and words offered on the random port have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Vault can take a command |
| cmd_op | input | 2 | 00 read, 01 update, 10 rekey, 11 reserved |
| cmd_data | input | 128 | Update payload: new key XOR current key |
| rnd_valid | input | 1 | Random word offered |
| rnd_ready | output | 1 | Vault is waiting for a random word |
| rnd_data | input | 32 | Random word used as the new Z |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_data | output | 128 | Masked key |
| busy | output | 1 | Rekey in progress |
| err | output | 1 | One-cycle strobe for a rejected command |

## Verification
Two things can fall in the same cycle: the commit of a rekey when the random word arrives, and a host command that has been waiting at the port. The bench provokes this by holding an update valid across a rekey and delaying the random word by a few cycles. It then judges that the update was not taken on the commit edge, was taken on the following edge, and that a later read shows the recovered key masked with the new Z. Random mixes of reads, updates, rekeys and reserved codes, with random delays on the random word, run against a bench model of the key and Z.

// File: rtl/vault_pkg.sv
package vault_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_UPDATE = 2'b01,
    OP_REKEY  = 2'b10,
    OP_RSVD   = 2'b11
  } vault_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_RESP  = 2'b01,
    ST_FETCH = 2'b10
  } vault_state_e;

endpackage

// File: rtl/vault_mask.sv
module vault_mask #(
  parameter int KEY_W = 128,
  parameter int Z_W   = 32
) (
  input  logic [KEY_W-1:0] din,
  input  logic [Z_W-1:0]   zval,
  output logic [KEY_W-1:0] dout
);
  localparam int REPS = KEY_W / Z_W;

  for (genvar i = 0; i < REPS; i++) begin : g_lane
    assign dout[i*Z_W +: Z_W] = din[i*Z_W +: Z_W] ^ zval;
  end
endmodule

// File: rtl/vault_store.sv
module vault_store #(
  parameter int              KEY_W    = 128,
  parameter int              Z_W      = 32,
  parameter logic [KEY_W-1:0] INIT_KEY = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_upd,
  input  logic [KEY_W-1:0] w_upd,
  input  logic             ld_rekey,
  input  logic [KEY_W-1:0] w_rekey,
  input  logic [Z_W-1:0]   z_new,
  output logic [KEY_W-1:0] wrapped,
  output logic [Z_W-1:0]   zcur,
  output logic             z_loaded
);
  // With no Z loaded, Z is zero, so the masked form equals the initial key.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrapped  <= INIT_KEY;
      zcur     <= '0;
      z_loaded <= 1'b0;
    end else if (ld_rekey) begin
      wrapped  <= w_rekey;
      zcur     <= z_new;
      z_loaded <= 1'b1;
    end else if (ld_upd) begin
      wrapped  <= w_upd;
    end
  end

  p_zl_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    z_loaded |=> z_loaded);
  p_no_double_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_upd && ld_rekey));
endmodule

// File: rtl/vault_ctrl.sv
module vault_ctrl
  import vault_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       z_loaded,
  input  logic       rnd_valid,
  output logic       cmd_ready,
  output logic       rnd_ready,
  output logic       busy,
  output logic       rsp_valid,
  output logic       err,
  output logic       ld_upd,
  output logic       ld_rekey
);
  vault_state_e state, state_nx;
  vault_op_e    op;
  logic         accept;
  logic         reject;

  assign op        = vault_op_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE);
  assign rnd_ready = (state == ST_FETCH);
  assign busy      = (state == ST_FETCH);
  assign rsp_valid = (state == ST_RESP);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    reject = 1'b0;
    if (accept) begin
      unique case (op)
        OP_READ, OP_UPDATE: reject = !z_loaded;
        OP_RSVD:            reject = 1'b1;
        default:            reject = 1'b0;
      endcase
    end
  end

  assign ld_upd   = accept && (op == OP_UPDATE) && z_loaded;
  assign ld_rekey = (state == ST_FETCH) && rnd_valid;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (accept && !reject) begin
          if (op == OP_READ)       state_nx = ST_RESP;
          else if (op == OP_REKEY) state_nx = ST_FETCH;
        end
      end
      ST_RESP:  state_nx = ST_IDLE;
      ST_FETCH: if (rnd_valid) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      err   <= 1'b0;
    end else begin
      state <= state_nx;
      err   <= reject;
    end
  end

  p_rsp_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_rsp_blocks_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
  p_busy_blocks_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!cmd_ready && rnd_ready));
  p_rnd_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_ready |-> busy);
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rsp_valid);
  p_busy_ends_on_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rnd_valid) |=> busy);
endmodule

// File: rtl/wrapped_key_vault.sv
module wrapped_key_vault #(
  parameter int               KEY_W    = 128,
  parameter int               Z_W      = 32,
  parameter logic [KEY_W-1:0] INIT_KEY = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [KEY_W-1:0] cmd_data,
  input  logic             rnd_valid,
  output logic             rnd_ready,
  input  logic [Z_W-1:0]   rnd_data,
  output logic             rsp_valid,
  output logic [KEY_W-1:0] rsp_data,
  output logic             busy,
  output logic             err
);
  logic [KEY_W-1:0] wrapped;
  logic [Z_W-1:0]   zcur;
  logic             z_loaded;
  logic [KEY_W-1:0] plain_cur;
  logic [KEY_W-1:0] plain_upd;
  logic [KEY_W-1:0] w_upd;
  logic [KEY_W-1:0] w_rekey;
  logic             ld_upd;
  logic             ld_rekey;

  // Key recovery: plain key = stored ^ Z; new key = payload ^ plain key.
  vault_mask #(.KEY_W(KEY_W), .Z_W(Z_W)) u_unwrap (
    .din(wrapped), .zval(zcur), .dout(plain_cur));

  assign plain_upd = cmd_data ^ plain_cur;

  vault_mask #(.KEY_W(KEY_W), .Z_W(Z_W)) u_wrap_upd (
    .din(plain_upd), .zval(zcur), .dout(w_upd));

  vault_mask #(.KEY_W(KEY_W), .Z_W(Z_W)) u_wrap_rekey (
    .din(plain_cur), .zval(rnd_data), .dout(w_rekey));

  vault_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .z_loaded(z_loaded),
    .rnd_valid(rnd_valid),
    .cmd_ready(cmd_ready), .rnd_ready(rnd_ready), .busy(busy),
    .rsp_valid(rsp_valid), .err(err),
    .ld_upd(ld_upd), .ld_rekey(ld_rekey));

  vault_store #(.KEY_W(KEY_W), .Z_W(Z_W), .INIT_KEY(INIT_KEY)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_upd(ld_upd), .w_upd(w_upd),
    .ld_rekey(ld_rekey), .w_rekey(w_rekey), .z_new(rnd_data),
    .wrapped(wrapped), .zcur(zcur), .z_loaded(z_loaded));

  // Only the masked register reaches the response bus, and only while a response is shown.
  assign rsp_data = rsp_valid ? wrapped : '0;

  p_reject_keeps_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !z_loaded && cmd_op != 2'b10) |=> $stable(wrapped));
  p_rekey_wait_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rnd_valid) |=> ($stable(wrapped) && $stable(zcur)));
  p_idle_rnd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_valid && cmd_ready)) |=> $stable(zcur));
  p_rsvd_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'b11) |=> ($stable(wrapped) && err));
endmodule

// File: tb/wrapped_key_vault_test.sv
module wrapped_key_vault_test;
  localparam int KEY_W = 128;
  localparam int Z_W   = 32;
  localparam int REPS  = KEY_W / Z_W;
  localparam logic [KEY_W-1:0] K0 = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [1:0]       cmd_op = 2'b00;
  logic [KEY_W-1:0] cmd_data = '0;
  logic             rnd_valid = 1'b0;
  logic             rnd_ready;
  logic [Z_W-1:0]   rnd_data = '0;
  logic             rsp_valid;
  logic [KEY_W-1:0] rsp_data;
  logic             busy;
  logic             err;

  int n_chk = 0;
  int n_bad = 0;

  logic [KEY_W-1:0] m_key;
  logic [Z_W-1:0]   m_z;
  logic             m_zl;
  logic             acc;

  always #5 clk = ~clk;

  wrapped_key_vault #(.KEY_W(KEY_W), .Z_W(Z_W), .INIT_KEY(K0)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rnd_valid(rnd_valid), .rnd_ready(rnd_ready), .rnd_data(rnd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .err(err));

  always @(posedge clk) acc <= cmd_valid && cmd_ready;

  function automatic logic [KEY_W-1:0] rep(input logic [Z_W-1:0] z);
    logic [KEY_W-1:0] r;
    for (int i = 0; i < REPS; i++) r[i*Z_W +: Z_W] = z;
    return r;
  endfunction

  task automatic chk(input string req, input logic [KEY_W-1:0] act, input logic [KEY_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [KEY_W-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    forever begin
      @(posedge clk); #1;
      if (acc) break;
    end
    cmd_valid = 1'b0;
  endtask

  task automatic do_read(input string req);
    issue(2'b00, '0);
    if (m_zl) begin
      chk({req, " R4 rsp_valid"}, {127'd0, rsp_valid}, 128'd1);
      chk({req, " R4 cmd_ready low"}, {127'd0, cmd_ready}, 128'd0);
      chk({req, " R3 data"}, rsp_data, m_key ^ rep(m_z));
      @(posedge clk); #1;
      chk({req, " R4 strobe ends"}, {127'd0, rsp_valid}, 128'd0);
    end else begin
      chk({req, " R7 err"}, {127'd0, err}, 128'd1);
      chk({req, " R7 no rsp"}, {127'd0, rsp_valid}, 128'd0);
    end
  endtask

  task automatic do_update(input logic [KEY_W-1:0] newkey, input string req);
    logic [KEY_W-1:0] msg;
    msg = newkey ^ m_key;
    issue(2'b01, msg);
    chk({req, " R2/R7 err"}, {127'd0, err}, {127'd0, !m_zl});
    if (m_zl) m_key = newkey;
  endtask

  task automatic do_rekey(input logic [Z_W-1:0] z, input int dly, input string req);
    issue(2'b10, '0);
    for (int i = 0; i < dly; i++) begin
      chk({req, " R6 busy"}, {125'd0, busy, rnd_ready, cmd_ready}, {125'd0, 3'b110});
      @(posedge clk); #1;
    end
    @(negedge clk);
    rnd_valid = 1'b1; rnd_data = z;
    @(posedge clk); #1;
    rnd_valid = 1'b0;
    chk({req, " R6 busy clears"}, {126'd0, busy, cmd_ready}, {126'd0, 2'b01});
    m_z = z; m_zl = 1'b1;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [Z_W-1:0] zz;
    logic [KEY_W-1:0] kk;
    void'($urandom(32'h5EED_0042));
    m_key = K0; m_z = '0; m_zl = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 outputs", {123'd0, cmd_ready, busy, rnd_ready, rsp_valid, err}, {123'd0, 5'b10000});

    // R7 read and update before any Z
    do_read("pre-Z read");
    @(posedge clk); #1;
    do_update(128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, "pre-Z update");
    @(posedge clk); #1;

    // R9 random port ignored while idle
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rnd_valid = 1'b1; rnd_data = $urandom;
      @(posedge clk); #1;
      chk("R9 rnd_ready idle", {127'd0, rnd_ready}, 128'd0);
    end
    rnd_valid = 1'b0;

    // R5 first rekey: key stays K0 (R1, R7), masked with new Z
    do_rekey(32'hA5A5_3C3C, 2, "first rekey R5");
    do_read("after first rekey R1 R5");

    // R2 update
    do_update(128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321, "update R2");
    do_read("after update R2");

    // R9 again with Z loaded
    @(negedge clk); rnd_valid = 1'b1; rnd_data = 32'hFFFF_0000;
    @(posedge clk); #1; rnd_valid = 1'b0;
    do_read("idle rnd ignored R9");

    // R8 reserved op
    issue(2'b11, {4{32'hCAFE_F00D}});
    chk("R8 err", {127'd0, err}, 128'd1);
    do_read("after reserved R8");

    // R6 overlap: update held during rekey, word arrives late
    issue(2'b10, '0);
    @(negedge clk);
    kk = 128'hFEDC_BA98_7654_3210_0011_2233_4455_6677;
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_data = kk ^ m_key;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R6 held off", {127'd0, acc}, 128'd0);
    end
    @(negedge clk); rnd_valid = 1'b1; rnd_data = 32'h0BAD_F00D;
    @(posedge clk); #1; rnd_valid = 1'b0;
    chk("R6 not on commit edge", {127'd0, acc}, 128'd0);
    m_z = 32'h0BAD_F00D;
    @(posedge clk); #1;
    chk("R6 taken after commit", {127'd0, acc}, 128'd1);
    cmd_valid = 1'b0;
    m_key = kk;
    do_read("after overlap R6 R2");

    // Rekey with zero delay
    do_rekey(32'h0000_0001, 0, "immediate rekey R5");
    do_read("after immediate rekey R5");

    // Random mix
    for (int n = 0; n < 60; n++) begin
      int sel;
      sel = $urandom_range(0, 3);
      case (sel)
        0: do_read("rand read R3");
        1: begin
          kk = {$urandom, $urandom, $urandom, $urandom};
          do_update(kk, "rand update R2");
        end
        2: begin
          zz = $urandom;
          do_rekey(zz, $urandom_range(0, 5), "rand rekey R5");
        end
        default: begin
          issue(2'b11, {$urandom, $urandom, $urandom, $urandom});
          chk("rand reserved R8", {127'd0, err}, 128'd1);
        end
      endcase
      if ((n % 8) == 7) do_read("rand check R3");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule